// File: doc/BRIEF.md
# Packet-Organized OTP Read Controller

This block sits between a register bus and a one-time-programmable word array whose contents form a chain of variable-length packets. Each packet begins with a header word. An 8-bit size field in that header sets how many payload words follow it. Software never reads the array directly. It writes a word address into the mode register and sets the start bit. The controller then walks the header chain from word 0 until it reaches the packet whose span covers that address. It copies that packet's header into a header register and its payload into a local buffer. A busy flag stays up for the whole transfer.

When the transfer is done, software reads the header from one register. It reads the payload one word at a time through a data register, which is indexed by a payload pointer that advances on each read. An address anywhere inside a packet returns the whole packet, starting at its header. The addressed word on its own is never returned. A walk that reaches an empty header (size 0) or runs past the end of the array ends with a zero header and an empty payload. The array is a synchronous ROM whose contents are given by a parameter vector. Words not covered by that vector read as zero.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset, the control register (offset 0x00), pointer register (0x08), status register (0x0C), header register (0x20) and data register (0x24) all read zero.
- R2: Writing a word with bit 6 set to the control register while idle starts a load. Status bit 6 reads 1 from the next cycle on. Control bit 6 reads 1 only until the load is accepted, which happens one cycle later, and reads 0 from then on.
- R3: Count the write edge as cycle 0. A load that finds the packet reached after skipping k packets, with L payload words, clears status bit 6 after exactly 2k+L+4 cycles. A load that stops on an empty header after k packets takes 2k+3 cycles. A load that runs off the array end after k packets takes 2k+2 cycles.
- R4: Bits 31:16 of the mode register (offset 0x04) give the target word address. The walk starts at word 0. Any target in [start of packet k, start of packet k+1) loads packet k, and its header word appears at offset 0x20.
- R5: A header whose bits 15:8 hold a nonzero value S is followed by S+1 payload words, so the packet spans S+2 words. Successive reads of offset 0x24 return those payload words in order, and each read advances the pointer by one.
- R6: A data read with the pointer at or beyond the payload length returns zero and leaves the pointer unchanged.
- R7: Writing the pointer register loads the pointer from the written bits 8:0. Writing 0 rewinds to the first payload word. Every new load also resets the pointer to 0.
- R8: A walk that reaches a header with bits 15:8 equal to zero ends the load. The header register then reads zero and data reads return zero.
- R9: A walk whose next header position is at or beyond the array size ends with the header register at zero. Payload words that lie past the array end are copied as zero.
- R10: A start command written while a load is in progress is ignored. A mode-register write during a load does not change the packet being loaded.
- R11: The mode register holds and reads back the full 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe; a read of 0x24 advances the payload pointer |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The bench builds two instances, each with a 64-word array and a 64-word contents vector, and keeps the default 8-bit size field. In the first instance the packet chain ends on an empty header. In the second, the packets fill the array and the last one runs past its end. With an array this small, both failure paths, zero-filled payload words past the end and walks over many packets are reached within a few dozen cycles. Exact load latency is then checked against a count derived from the packet layout.

// File: rtl/otp_pkt_pkg.sv
// Shared constants and types for the packet OTP read controller.
// Assumes a 6-bit byte-offset register bus and the fixed header layout below.
package otp_pkt_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFF_CMD  = 6'h00;
    localparam logic [REG_AW-1:0] OFF_MODE = 6'h04;
    localparam logic [REG_AW-1:0] OFF_PTR  = 6'h08;
    localparam logic [REG_AW-1:0] OFF_STAT = 6'h0C;
    localparam logic [REG_AW-1:0] OFF_HDR  = 6'h20;
    localparam logic [REG_AW-1:0] OFF_DATA = 6'h24;

    localparam int START_BIT = 6;   // control: start a packet load
    localparam int BUSY_BIT  = 6;   // status: transfer in progress
    localparam int TGT_LSB   = 16;  // mode: target word address LSB
    localparam int TGT_W     = 16;
    localparam int SIZE_LSB  = 8;   // header: payload size field LSB
    localparam int SIZE_W    = 8;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH,
        W_EXAM,
        W_COPY,
        W_DRAIN
    } walk_state_t;

endpackage

// File: rtl/otp_rom.sv
// Synchronous read-only word array. Words below INIT_WORDS (and below WORDS)
// come from the IMAGE vector, word 0 in the low 32 bits; all others read 0.
// Assumes INIT_WORDS >= 2. One cycle of read latency.
module otp_rom #(
    parameter int WORDS      = 2816,
    parameter int INIT_WORDS = 16,
    parameter logic [INIT_WORDS*32-1:0] IMAGE = '0,
    parameter int AW         = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [31:0]   rdata
);
    localparam int IW    = $clog2(INIT_WORDS);
    localparam int LIM_I = (WORDS < INIT_WORDS) ? WORDS : INIT_WORDS;
    localparam logic [AW-1:0] LIM = AW'(LIM_I);

    logic [31:0] words [INIT_WORDS];

    for (genvar g = 0; g < INIT_WORDS; g++) begin : g_unpack
        assign words[g] = IMAGE[g*32 +: 32];
    end

    // Registered read; out-of-image addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (addr < LIM) begin
            rdata <= words[addr[IW-1:0]];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/otp_pkt_walker.sv
// Header-chain walker: on start, scans headers from word 0 until the packet
// whose span covers the target is found, then streams its payload into the
// buffer. Assumes a ROM with one cycle of latency and start only while idle.
module otp_pkt_walker
    import otp_pkt_pkg::*;
#(
    parameter int OTP_WORDS = 2816,
    parameter int AW        = 17,
    parameter int SZ_W      = 8,
    parameter int TG_W      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TG_W-1:0] target,
    output logic [AW-1:0]   rom_addr,
    input  logic [31:0]     rom_rdata,
    output logic            busy,
    output logic [31:0]     hdr,
    output logic [SZ_W:0]   pl_len,
    output logic            buf_we,
    output logic [SZ_W-1:0] buf_widx,
    output logic [31:0]     buf_wdata
);
    localparam logic [AW-1:0] END_POS = AW'(OTP_WORDS);
    localparam logic [SZ_W:0] ONE_L   = (SZ_W+1)'(1);

    walk_state_t     state_q;
    logic [AW-1:0]   pos_q;
    logic [AW-1:0]   tgt_q;
    logic [31:0]     hdr_q;
    logic [SZ_W:0]   len_q;
    logic [SZ_W-1:0] iss_q;
    logic [SZ_W-1:0] widx_q;
    logic            wv_q;

    logic [SZ_W-1:0] size_f;
    logic [AW-1:0]   next_pos;
    logic            hit;
    logic            last_iss;

    // Decode the header currently returned by the ROM.
    always_comb begin
        size_f   = rom_rdata[SIZE_LSB +: SZ_W];
        next_pos = pos_q + AW'(size_f) + AW'(2);
        hit      = tgt_q < next_pos;
        last_iss = ({1'b0, iss_q} == (len_q - ONE_L));
    end

    // ROM address: header position while walking, payload word while copying.
    always_comb begin
        if (state_q == W_COPY) begin
            rom_addr = pos_q + AW'(1) + AW'(iss_q);
        end else begin
            rom_addr = pos_q;
        end
    end

    // Walk and copy sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            pos_q   <= '0;
            tgt_q   <= '0;
            hdr_q   <= '0;
            len_q   <= '0;
            iss_q   <= '0;
            widx_q  <= '0;
            wv_q    <= 1'b0;
        end else begin
            wv_q   <= (state_q == W_COPY);
            widx_q <= iss_q;
            case (state_q)
                W_IDLE: begin
                    if (start) begin
                        tgt_q   <= AW'(target);
                        pos_q   <= '0;
                        hdr_q   <= '0;
                        len_q   <= '0;
                        state_q <= W_FETCH;
                    end
                end
                W_FETCH: begin
                    state_q <= (pos_q >= END_POS) ? W_IDLE : W_EXAM;
                end
                W_EXAM: begin
                    if (size_f == '0) begin
                        state_q <= W_IDLE;
                    end else if (hit) begin
                        hdr_q   <= rom_rdata;
                        len_q   <= (SZ_W+1)'(size_f) + ONE_L;
                        iss_q   <= '0;
                        state_q <= W_COPY;
                    end else begin
                        pos_q   <= next_pos;
                        state_q <= W_FETCH;
                    end
                end
                W_COPY: begin
                    if (last_iss) begin
                        state_q <= W_DRAIN;
                    end else begin
                        iss_q <= iss_q + 1'b1;
                    end
                end
                W_DRAIN: state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != W_IDLE);
    assign hdr       = hdr_q;
    assign pl_len    = len_q;
    assign buf_we    = wv_q;
    assign buf_widx  = widx_q;
    assign buf_wdata = rom_rdata;

    // R4: the walk never steps past the target.
    a_r4_walk_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_EXAM) |-> (tgt_q >= pos_q))
        else $error("R4 walk passed target");

    // R3: copy never issues beyond the payload length.
    a_r3_copy_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_COPY) |-> ({1'b0, iss_q} < len_q))
        else $error("R3 copy index overrun");

    // R8: empty header terminates the load with zeroed results.
    a_r8_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_EXAM && size_f == '0) |=> (state_q == W_IDLE && hdr_q == '0 && len_q == '0))
        else $error("R8 empty header not handled");

    // R9: walking past the array end terminates with a zero header.
    a_r9_end_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_FETCH && pos_q >= END_POS) |=> (state_q == W_IDLE && hdr_q == '0))
        else $error("R9 array end not handled");

endmodule

// File: rtl/otp_payload_buf.sv
// Payload holding buffer with a read pointer. Written by the walker, read by
// the register port; reads at or past the length return zero and hold.
// Assumes clr and load are never needed in the same cycle (clr wins).
module otp_payload_buf #(
    parameter int SZ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SZ_W-1:0] widx,
    input  logic [31:0]     wdata,
    input  logic [SZ_W:0]   len,
    input  logic            clr,
    input  logic            load,
    input  logic [SZ_W:0]   load_val,
    input  logic            pop,
    output logic [SZ_W:0]   ptr,
    output logic [31:0]     rdata
);
    localparam int DEPTH = 2 ** SZ_W;

    logic [31:0]   mem [DEPTH];
    logic [SZ_W:0] ptr_q;

    // Payload storage write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read pointer: rewind, software load, or advance on a read in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (pop && ptr_q < len) begin
            ptr_q <= ptr_q + (SZ_W+1)'(1);
        end
    end

    assign ptr   = ptr_q;
    assign rdata = (ptr_q < len) ? mem[ptr_q[SZ_W-1:0]] : '0;

    // R6: a read past the end leaves the pointer in place.
    a_r6_hold_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr && !load && ptr_q >= len) |=> $stable(ptr_q))
        else $error("R6 pointer moved past end");

    // R5: a read in range advances the pointer by one.
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr && !load && ptr_q < len) |=> (ptr_q == $past(ptr_q) + (SZ_W+1)'(1)))
        else $error("R5 pointer step wrong");

endmodule

// File: rtl/otp_pkt_reader.sv
// Register front end of the packet OTP read controller. Decodes the bus,
// holds the mode register and start request, and ties together ROM, walker
// and payload buffer. Assumes OTP_WORDS <= 2**TG_W.
module otp_pkt_reader
    import otp_pkt_pkg::*;
#(
    parameter int OTP_WORDS  = 2816,
    parameter int INIT_WORDS = 16,
    parameter logic [INIT_WORDS*32-1:0] IMAGE = '0,
    parameter int SZ_W       = SIZE_W,
    parameter int TG_W       = TGT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int AW = TG_W + 1;

    logic [31:0]     mode_q;
    logic            pend_q;
    logic            walk_busy;
    logic            stat_busy;
    logic            start_req;
    logic [AW-1:0]   rom_addr;
    logic [31:0]     rom_rdata;
    logic [31:0]     hdr;
    logic [SZ_W:0]   pl_len;
    logic            buf_we;
    logic [SZ_W-1:0] buf_widx;
    logic [31:0]     buf_wdata;
    logic [SZ_W:0]   ptr;
    logic [31:0]     buf_rdata;
    logic            pop;
    logic            ptr_load;

    assign stat_busy = pend_q | walk_busy;
    assign start_req = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[START_BIT] && !stat_busy;
    assign pop       = reg_rd && (reg_addr == OFF_DATA) && !stat_busy;
    assign ptr_load  = reg_wr && (reg_addr == OFF_PTR);

    // Mode register: holds the target address field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (reg_wr && reg_addr == OFF_MODE) begin
            mode_q <= reg_wdata;
        end
    end

    // Start request: set by the command write, cleared when the walker accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (start_req) begin
            pend_q <= 1'b1;
        end else begin
            pend_q <= 1'b0;
        end
    end

    // Read-data mux for the register port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CMD:  reg_rdata[START_BIT] = pend_q;
            OFF_MODE: reg_rdata = mode_q;
            OFF_PTR:  reg_rdata = 32'(ptr);
            OFF_STAT: reg_rdata[BUSY_BIT] = stat_busy;
            OFF_HDR:  reg_rdata = hdr;
            OFF_DATA: reg_rdata = stat_busy ? '0 : buf_rdata;
            default:  reg_rdata = '0;
        endcase
    end

    otp_rom #(
        .WORDS      (OTP_WORDS),
        .INIT_WORDS (INIT_WORDS),
        .IMAGE      (IMAGE),
        .AW         (AW)
    ) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (rom_addr),
        .rdata (rom_rdata)
    );

    otp_pkt_walker #(
        .OTP_WORDS (OTP_WORDS),
        .AW        (AW),
        .SZ_W      (SZ_W),
        .TG_W      (TG_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pend_q),
        .target    (mode_q[TGT_LSB +: TG_W]),
        .rom_addr  (rom_addr),
        .rom_rdata (rom_rdata),
        .busy      (walk_busy),
        .hdr       (hdr),
        .pl_len    (pl_len),
        .buf_we    (buf_we),
        .buf_widx  (buf_widx),
        .buf_wdata (buf_wdata)
    );

    otp_payload_buf #(
        .SZ_W (SZ_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (buf_we),
        .widx     (buf_widx),
        .wdata    (buf_wdata),
        .len      (pl_len),
        .clr      (pend_q),
        .load     (ptr_load),
        .load_val (reg_wdata[SZ_W:0]),
        .pop      (pop),
        .ptr      (ptr),
        .rdata    (buf_rdata)
    );

    // R2: an accepted start raises busy on the next cycle.
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CMD && reg_wdata[START_BIT] && !stat_busy) |=> stat_busy)
        else $error("R2 start did not raise busy");

    // R2: the start request self-clears after one cycle.
    a_r2_cmd_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q)
        else $error("R2 start bit stuck");

    // R10: no new request is raised while a load runs.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> !pend_q)
        else $error("R10 start accepted while busy");

endmodule

// File: tb/otp_pkt_reader_tb.sv
module otp_pkt_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 64;

    localparam logic [5:0] A_CMD  = 6'h00;
    localparam logic [5:0] A_MODE = 6'h04;
    localparam logic [5:0] A_PTR  = 6'h08;
    localparam logic [5:0] A_STAT = 6'h0C;
    localparam logic [5:0] A_HDR  = 6'h20;
    localparam logic [5:0] A_DATA = 6'h24;

    // Contents: variant 0 ends in an empty header, variant 1 overruns the end.
    function automatic logic [NW*32-1:0] build_img(input int variant);
        logic [NW*32-1:0] img;
        int pos;
        int s;
        bit done;
        img  = '0;
        pos  = 0;
        done = 1'b0;
        for (int i = 0; i < NW; i++) begin
            if (!done) begin
                s = ((i * 5 + 3) % 6) + 1;
                if (variant == 0 && pos + s + 2 > 56) begin
                    done = 1'b1;
                end else if (variant != 0 && pos >= NW) begin
                    done = 1'b1;
                end else begin
                    img[pos*32 +: 32] = {8'h5A, 8'(i * 3 + 1), 8'(s), 8'(i)};
                    for (int j = 0; j <= 6; j++) begin
                        if (j <= s && pos + 1 + j < NW) begin
                            img[(pos+1+j)*32 +: 32] = {8'(pos + 1 + j), 8'hC3, 8'(i), 8'(j)} ^ 32'h00F0_0F00;
                        end
                    end
                    pos = pos + s + 2;
                end
            end
        end
        return img;
    endfunction

    localparam logic [NW*32-1:0] IMG_A = build_img(0);
    localparam logic [NW*32-1:0] IMG_B = build_img(1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 1'b0, a_rd = 1'b0;
    logic [5:0]  a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_pkt_reader #(
        .OTP_WORDS (NW), .INIT_WORDS (NW), .IMAGE (IMG_A)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (a_wr), .reg_rd (a_rd),
        .reg_addr (a_addr), .reg_wdata (a_wdata), .reg_rdata (a_rdata)
    );

    otp_pkt_reader #(
        .OTP_WORDS (NW), .INIT_WORDS (NW), .IMAGE (IMG_B)
    ) u_dut_b (
        .clk (clk), .rst_n (rst_n), .reg_wr (b_wr), .reg_rd (b_rd),
        .reg_addr (b_addr), .reg_wdata (b_wdata), .reg_rdata (b_rdata)
    );

    function automatic logic [31:0] wd(input logic [NW*32-1:0] img, input int idx);
        if (idx >= 0 && idx < NW) return img[idx*32 +: 32];
        return 32'h0;
    endfunction

    // Expected result of a load: header, packet base (-1 on failure), cycles busy.
    task automatic model(input logic [NW*32-1:0] img, input int target,
                         output logic [31:0] hdr, output int base, output int cyc);
        int pos = 0;
        int k = 0;
        int s;
        logic [31:0] h;
        bit fin = 1'b0;
        hdr = '0;
        base = -1;
        cyc = 0;
        while (!fin) begin
            if (pos >= NW) begin
                cyc = 2 * k + 2;
                fin = 1'b1;
            end else begin
                h = wd(img, pos);
                s = int'(h[15:8]);
                if (s == 0) begin
                    cyc = 2 * k + 3;
                    fin = 1'b1;
                end else if (target < pos + s + 2) begin
                    hdr = h;
                    base = pos;
                    cyc = 2 * k + (s + 1) + 4;
                    fin = 1'b1;
                end else begin
                    pos = pos + s + 2;
                    k++;
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input int which, input logic [5:0] adr, input logic [31:0] d);
        @(negedge clk);
        if (which == 0) begin a_wr = 1'b1; a_addr = adr; a_wdata = d; end
        else            begin b_wr = 1'b1; b_addr = adr; b_wdata = d; end
        @(posedge clk);
        #1;
        a_wr = 1'b0;
        b_wr = 1'b0;
    endtask

    task automatic br(input int which, input logic [5:0] adr, output logic [31:0] d);
        @(negedge clk);
        if (which == 0) begin a_rd = 1'b1; a_addr = adr; end
        else            begin b_rd = 1'b1; b_addr = adr; end
        #1;
        d = (which == 0) ? a_rdata : b_rdata;
        @(posedge clk);
        #1;
        a_rd = 1'b0;
        b_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Full load of one target and check of everything observable about it.
    task automatic check_pkt(input int which, input logic [NW*32-1:0] img, input int target);
        logic [31:0] eh;
        logic [31:0] d;
        int base;
        int cyc;
        int polls;
        int len;
        model(img, target, eh, base, cyc);
        bw(which, A_MODE, {target[15:0], 16'h0});
        bw(which, A_CMD, 32'h0000_0040);
        polls = 0;
        do begin
            br(which, A_STAT, d);
            if (polls == 0) chk("R2 busy after start", d & 32'h40, 32'h40);
            polls++;
        end while (d[6] && polls < 2000);
        chk("R3 load cycles", 32'(polls), 32'(cyc + 1));
        br(which, A_CMD, d);
        chk("R2 start bit self-clear", d & 32'h40, 32'h0);
        br(which, A_HDR, d);
        chk(base >= 0 ? "R4 header of covering packet" : "R8/R9 failed load header", d, eh);
        if (base >= 0) begin
            len = int'(eh[15:8]) + 1;
            for (int j = 0; j < len; j++) begin
                br(which, A_DATA, d);
                chk("R5 payload word in order", d, wd(img, base + 1 + j));
            end
            br(which, A_DATA, d);
            chk("R6 read past end is zero", d, 32'h0);
            br(which, A_PTR, d);
            chk("R6 pointer holds at end", d, 32'(len));
            bw(which, A_PTR, 32'h0);
            br(which, A_DATA, d);
            chk("R7 rewind to first word", d, wd(img, base + 1));
            if (len > 2) begin
                bw(which, A_PTR, 32'h2);
                br(which, A_DATA, d);
                chk("R7 pointer load", d, wd(img, base + 3));
            end
        end else begin
            br(which, A_DATA, d);
            chk("R8 empty payload after failed load", d, 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] eh;
        int base;
        int cyc;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values.
        br(0, A_STAT, d); chk("R1 status reset", d, 32'h0);
        br(0, A_HDR, d);  chk("R1 header reset", d, 32'h0);
        br(0, A_PTR, d);  chk("R1 pointer reset", d, 32'h0);
        br(0, A_CMD, d);  chk("R1 control reset", d, 32'h0);
        br(0, A_DATA, d); chk("R1 data reset", d, 32'h0);

        // R11: mode register readback.
        bw(0, A_MODE, 32'h1234_5678);
        br(0, A_MODE, d); chk("R11 mode readback", d, 32'h1234_5678);

        // Directed: first word, packet interiors and edges, termination.
        check_pkt(0, IMG_A, 0);
        check_pkt(0, IMG_A, 5);
        check_pkt(0, IMG_A, 6);
        check_pkt(0, IMG_A, 54);
        check_pkt(0, IMG_A, 55);
        check_pkt(0, IMG_A, 60);
        check_pkt(0, IMG_A, 9000);
        check_pkt(1, IMG_B, 0);
        check_pkt(1, IMG_B, 62);
        check_pkt(1, IMG_B, 63);
        check_pkt(1, IMG_B, 70);
        check_pkt(1, IMG_B, 60000);

        // R10: start and mode writes during a load are ignored.
        model(IMG_A, 20, eh, base, cyc);
        bw(0, A_MODE, 32'h0014_0000);
        bw(0, A_CMD, 32'h0000_0040);
        bw(0, A_MODE, 32'h0000_0000);
        bw(0, A_CMD, 32'h0000_0040);
        for (int n = 0; n < 100; n++) begin
            br(0, A_STAT, d);
            if (!d[6]) break;
        end
        br(0, A_HDR, d);  chk("R10 load unaffected by writes while busy", d, eh);
        br(0, A_STAT, d); chk("R10 no second load started", d & 32'h40, 32'h0);
        br(0, A_DATA, d); chk("R10 payload of original packet", d, wd(IMG_A, base + 1));

        // Random targets on both instances.
        for (int n = 0; n < 30; n++) check_pkt(0, IMG_A, int'($urandom_range(0, 70)));
        for (int n = 0; n < 15; n++) check_pkt(1, IMG_B, int'($urandom_range(0, 80)));

        finish_run();
    end
endmodule